// File: doc/BRIEF.md
# System Clock Mode Controller

This block holds one byte-wide control register on a simple register bus and uses it to run the system clock. It picks either the main oscillator or the sub oscillator as the clock source. It then divides that source by one of four ratios and produces a one-cycle system clock enable pulse. It drives the enable for the main oscillator, so the main oscillator can be stopped while the system runs from the sub clock.

The block also watches two supply voltage detector flags, one for a higher threshold and one for a lower threshold. The flags arrive as digital inputs and pass through a synchroniser. When the lower-threshold flag trips, the block either requests a system reset or, if the freeze bit is set, requests a freeze instead. Software can read both flags from the same register. A separate bit switches detection off completely.

Changes to the source or to the ratio are held as pending values. They are adopted only when the current divided period ends, so the enable never produces a shortened period.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `main_osc_en` is 1, and both request outputs are 0. The register answers only at address 0xF5; a read of any other address returns 0, and a write to any other address has no effect. Read data appears one clock after the read strobe.
- R2: Bits [1:0] are the clock-control field. Codes 00 and 01 select the main tick as the source; codes 10 and 11 select the sub tick.
- R3: Bits [3:2] are the prescale field. Codes 00, 01, 10 and 11 give one `sys_ce` pulse, one clock wide, for every 2, 8, 16 or 64 ticks of the selected source.
- R4: From reset the system runs from the main tick divided by 2.
- R5: Bit 4 reads the synchronised higher-threshold flag and bit 5 reads the synchronised lower-threshold flag.
- R6: With bit 6 at 0, a set lower-threshold flag raises `sys_rst_req`. With bit 6 at 1, the same flag raises `freeze_req` and does not raise `sys_rst_req`.
- R7: Bit 7 at 1 disables detection: bits 5:4 read 0, and neither request is produced.
- R8: A new source or ratio takes effect only at the end of the divided period in progress. That period completes at the old setting.
- R9: `main_osc_en` goes low only while the clock-control field is 11 and the sub tick has become the active source.
- R10: Writes to bits 5:4 are ignored; those bits show only the flag inputs.
- R11: Once the trigger for `sys_rst_req` is gone, the request stays high for HOLD_CE further `sys_ce` pulses (2 by default), and it drops only on a `sys_ce` pulse. The request is therefore held for at least one full system clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | One-cycle pulse per main oscillator period |
| sub_tick | input | 1 | One-cycle pulse per sub oscillator period |
| vdet_hi | input | 1 | Higher-threshold voltage flag |
| vdet_lo | input | 1 | Lower-threshold voltage flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sys_ce | output | 1 | System clock enable pulse |
| main_osc_en | output | 1 | Main oscillator run enable |
| sys_rst_req | output | 1 | System reset request |
| freeze_req | output | 1 | Freeze request |

## Verification
The assertions make several assumptions about the inputs:
- Each tick input is a pulse at most one clock wide.
- The main tick is absent while `main_osc_en` is low.
- The voltage flags change slowly compared with the synchroniser depth.

The bench keeps within these assumptions. It generates the main and sub ticks at fixed spacings of 2 and 5 clocks, and it gates the main tick with `main_osc_en` as a real oscillator would behave. It changes the flags only from tasks, holds each level for many cycles, and never issues a read and a write in the same cycle.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  // Clock-control field codes
  typedef enum logic [1:0] {
    CC_MAIN_A  = 2'b00,
    CC_MAIN_B  = 2'b01,
    CC_SUB_RUN = 2'b10,
    CC_SUB_OFF = 2'b11
  } clk_ctl_e;

  // Writable fields of the control register
  typedef struct packed {
    logic       det_off;  // bit 7: detection disable
    logic       frz;      // bit 6: freeze instead of reset
    logic [1:0] ps;       // bits 3:2: prescale code
    logic [1:0] cc;       // bits 1:0: clock-control code
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '0;

endpackage

// File: rtl/sysclk_regfile.sv
module sysclk_regfile
  import sysclk_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hF5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              flag_hi,
  input  logic              flag_lo,
  output ctrl_t             ctrl,
  output logic [7:0]        rdata
);

  logic hit;
  logic unused_flag_bits;

  assign hit = (addr == REG_ADDR);

  // Bits 5:4 of a write are deliberately dropped (read-only flags)
  assign unused_flag_bits = ^wdata[5:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= CTRL_RESET;
    end else if (wr_en && hit) begin
      ctrl.det_off <= wdata[7];
      ctrl.frz     <= wdata[6];
      ctrl.ps      <= wdata[3:2];
      ctrl.cc      <= wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 8'h00;
    end else if (rd_en && hit) begin
      rdata <= {ctrl.det_off, ctrl.frz, flag_lo, flag_hi, ctrl.ps, ctrl.cc};
    end else begin
      rdata <= 8'h00;
    end
  end

endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 16,
  parameter int DIV_D = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       pend_sub,
  input  logic [1:0] pend_ps,
  output logic       sys_ce,
  output logic       act_sub,
  output logic [1:0] act_ps
);

  // DIV_D is the largest ratio and sizes the counter
  localparam int CNT_W = $clog2(DIV_D);
  localparam logic [CNT_W-1:0] LIM_A = CNT_W'(DIV_A - 1);
  localparam logic [CNT_W-1:0] LIM_B = CNT_W'(DIV_B - 1);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(DIV_C - 1);
  localparam logic [CNT_W-1:0] LIM_D = CNT_W'(DIV_D - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             tick;
  logic             wrap;

  always_comb begin
    case (act_ps)
      2'd0:    lim = LIM_A;
      2'd1:    lim = LIM_B;
      2'd2:    lim = LIM_C;
      default: lim = LIM_D;
    endcase
  end

  assign tick = act_sub ? sub_tick : main_tick;
  assign wrap = tick && (cnt == lim);

  // Active settings reload only on a period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sys_ce  <= 1'b0;
      act_sub <= 1'b0;
      act_ps  <= 2'd0;
    end else begin
      sys_ce <= wrap;
      if (wrap) begin
        cnt     <= '0;
        act_sub <= pend_sub;
        act_ps  <= pend_ps;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sysclk_vdet.sv
module sysclk_vdet #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CE     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vdet_hi,
  input  logic vdet_lo,
  input  logic det_off,
  input  logic frz,
  input  logic sys_ce,
  output logic flag_hi,
  output logic flag_lo,
  output logic sys_rst_req,
  output logic freeze_req
);

  localparam int HOLD_W = $clog2(HOLD_CE + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CE - 1);

  logic [SYNC_STAGES-1:0] hi_sync;
  logic [SYNC_STAGES-1:0] lo_sync;
  logic [HOLD_W-1:0]      hold_cnt;
  logic                   rst_trig;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) begin
          hi_sync <= '0;
          lo_sync <= '0;
        end else begin
          hi_sync <= vdet_hi;
          lo_sync <= vdet_lo;
        end
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          hi_sync <= '0;
          lo_sync <= '0;
        end else begin
          hi_sync <= {hi_sync[SYNC_STAGES-2:0], vdet_hi};
          lo_sync <= {lo_sync[SYNC_STAGES-2:0], vdet_lo};
        end
      end
    end
  endgenerate

  assign flag_hi  = !det_off && hi_sync[SYNC_STAGES-1];
  assign flag_lo  = !det_off && lo_sync[SYNC_STAGES-1];
  assign rst_trig = flag_lo && !frz;

  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_req <= 1'b0;
    end else begin
      freeze_req <= flag_lo && frz;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_req <= 1'b0;
      hold_cnt    <= '0;
    end else if (rst_trig) begin
      sys_rst_req <= 1'b1;
      hold_cnt    <= '0;
    end else if (sys_rst_req && sys_ce) begin
      if (hold_cnt == HOLD_LAST) begin
        sys_rst_req <= 1'b0;
        hold_cnt    <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
  import sysclk_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'hF5,
  parameter int                DIV_A       = 2,
  parameter int                DIV_B       = 8,
  parameter int                DIV_C       = 16,
  parameter int                DIV_D       = 64,
  parameter int                SYNC_STAGES = 2,
  parameter int                HOLD_CE     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              main_tick,
  input  logic              sub_tick,
  input  logic              vdet_hi,
  input  logic              vdet_lo,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              sys_ce,
  output logic              main_osc_en,
  output logic              sys_rst_req,
  output logic              freeze_req
);

  ctrl_t      ctrl;
  logic       flag_hi;
  logic       flag_lo;
  logic       act_sub;
  logic [1:0] act_ps;

  sysclk_regfile #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .flag_hi(flag_hi),
    .flag_lo(flag_lo),
    .ctrl   (ctrl),
    .rdata  (rdata)
  );

  sysclk_divider #(
    .DIV_A(DIV_A),
    .DIV_B(DIV_B),
    .DIV_C(DIV_C),
    .DIV_D(DIV_D)
  ) div_i (
    .clk      (clk),
    .rst      (rst),
    .main_tick(main_tick),
    .sub_tick (sub_tick),
    .pend_sub (ctrl.cc[1]),
    .pend_ps  (ctrl.ps),
    .sys_ce   (sys_ce),
    .act_sub  (act_sub),
    .act_ps   (act_ps)
  );

  sysclk_vdet #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_CE    (HOLD_CE)
  ) vdet_i (
    .clk        (clk),
    .rst        (rst),
    .vdet_hi    (vdet_hi),
    .vdet_lo    (vdet_lo),
    .det_off    (ctrl.det_off),
    .frz        (ctrl.frz),
    .sys_ce     (sys_ce),
    .flag_hi    (flag_hi),
    .flag_lo    (flag_lo),
    .sys_rst_req(sys_rst_req),
    .freeze_req (freeze_req)
  );

  // The oscillator stops only once the sub clock is actually in use
  always_ff @(posedge clk) begin
    if (rst) begin
      main_osc_en <= 1'b1;
    end else begin
      main_osc_en <= !((ctrl.cc == CC_SUB_OFF) && act_sub);
    end
  end

endmodule

// File: rtl/sysclk_mode_chk.sv
module sysclk_mode_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] rdata,
  input logic       sys_ce,
  input logic       main_osc_en,
  input logic       sys_rst_req,
  input logic       freeze_req,
  input logic [1:0] cc,
  input logic       frz,
  input logic       det_off,
  input logic [1:0] act_ps,
  input logic       act_sub
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdata == 8'h00 && main_osc_en && !sys_rst_req && !freeze_req));

  p_ce_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    sys_ce |=> !sys_ce);

  p_rst_not_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> !$past(frz));

  p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    (det_off && $past(det_off)) |-> !freeze_req);

  p_ratio_on_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_ps) |-> sys_ce);

  p_source_on_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_sub) |-> sys_ce);

  p_osc_off_only_stop_r9: assert property (@(posedge clk) disable iff (rst)
    !main_osc_en |-> $past(cc == 2'b11 && act_sub));

  p_release_on_ce_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_req) |-> $past(sys_ce));

endmodule

bind sysclk_mode_ctrl sysclk_mode_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .rdata      (rdata),
  .sys_ce     (sys_ce),
  .main_osc_en(main_osc_en),
  .sys_rst_req(sys_rst_req),
  .freeze_req (freeze_req),
  .cc         (ctrl.cc),
  .frz        (ctrl.frz),
  .det_off    (ctrl.det_off),
  .act_ps     (act_ps),
  .act_sub    (act_sub)
);

// File: tb/sysclk_mode_ctrl_tb.sv
`timescale 1ns/1ps
module sysclk_mode_ctrl_tb_top;

  localparam int MAIN_GAP = 2;
  localparam int SUB_GAP  = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       main_tick = 1'b0;
  logic       sub_tick = 1'b0;
  logic       vdet_hi = 1'b0;
  logic       vdet_lo = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sys_ce;
  logic       main_osc_en;
  logic       sys_rst_req;
  logic       freeze_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int main_ph = 0;
  int sub_ph = 0;

  sysclk_mode_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .main_tick  (main_tick),
    .sub_tick   (sub_tick),
    .vdet_hi    (vdet_hi),
    .vdet_lo    (vdet_lo),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .sys_ce     (sys_ce),
    .main_osc_en(main_osc_en),
    .sys_rst_req(sys_rst_req),
    .freeze_req (freeze_req)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Oscillator models: the main tick is absent while the oscillator is off
  always @(negedge clk) begin
    main_ph   = (main_ph + 1) % MAIN_GAP;
    sub_ph    = (sub_ph + 1) % SUB_GAP;
    main_tick = (main_ph == 0) && main_osc_en && !rst;
    sub_tick  = (sub_ph == 0) && !rst;
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_ce();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!sys_ce && guard < 2000);
  endtask

  task automatic measure(output int n);
    wait_ce();
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sys_ce && n < 2000);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    int p;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 osc_en", main_osc_en, 1);
    check_eq("R1 rst_req", sys_rst_req, 0);
    check_eq("R1 freeze", freeze_req, 0);
    bus_read(8'hF5, d);
    check_eq("R1 reset value", d, 8'h00);
    bus_write(8'hF4, 8'hCF);
    bus_read(8'hF5, d);
    check_eq("R1 other address write", d, 8'h00);
    bus_read(8'hF4, d);
    check_eq("R1 other address read", d, 8'h00);
    measure(p);
    measure(p);
    check_eq("R4 reset period main/2", p, 2 * MAIN_GAP);
  endtask

  task automatic t_ratios();
    int p;
    for (int code = 1; code < 4; code++) begin
      bus_write(8'hF5, 8'(code << 2));
      measure(p);
      measure(p);
      check_eq("R3 ratio", p, (code == 1 ? 8 : code == 2 ? 16 : 64) * MAIN_GAP);
    end
  endtask

  task automatic t_boundary();
    int t0;
    int p;
    bus_write(8'hF5, 8'h0C);
    measure(p);
    wait_ce();
    t0 = cyc;
    bus_write(8'hF5, 8'h00);
    wait_ce();
    check_eq("R8 old period completes", cyc - t0, 64 * MAIN_GAP);
    t0 = cyc;
    wait_ce();
    check_eq("R8 new period after boundary", cyc - t0, 2 * MAIN_GAP);
  endtask

  task automatic t_sources();
    int p;
    bus_write(8'hF5, 8'h02);
    measure(p);
    measure(p);
    check_eq("R2 sub running period", p, 2 * SUB_GAP);
    check_eq("R9 osc on with code 10", main_osc_en, 1);
    bus_write(8'hF5, 8'h03);
    repeat (3) @(negedge clk);
    check_eq("R9 osc off with code 11", main_osc_en, 0);
    measure(p);
    check_eq("R2 sub stopped-main period", p, 2 * SUB_GAP);
    bus_write(8'hF5, 8'h01);
    repeat (2) @(negedge clk);
    check_eq("R9 osc on with code 01", main_osc_en, 1);
    measure(p);
    measure(p);
    check_eq("R2 main via code 01", p, 2 * MAIN_GAP);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    vdet_hi = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(8'hF5, d);
    check_eq("R5 high flag bit 4", d, 8'h11);
    check_eq("R5 no reset from high flag", sys_rst_req, 0);
    vdet_hi = 1'b0;
    repeat (5) @(negedge clk);
    bus_write(8'hF5, 8'h31);
    bus_read(8'hF5, d);
    check_eq("R10 flag bits not writable", d, 8'h01);
  endtask

  task automatic t_reset_req();
    logic [7:0] d;
    int n;
    bus_write(8'hF5, 8'h04);
    repeat (40) @(negedge clk);
    vdet_lo = 1'b1;
    repeat (6) @(negedge clk);
    check_eq("R6 reset request", sys_rst_req, 1);
    check_eq("R6 no freeze", freeze_req, 0);
    bus_read(8'hF5, d);
    check_eq("R5 low flag bit 5", d, 8'h24);
    vdet_lo = 1'b0;
    n = 0;
    while (sys_rst_req && n < 500) begin
      @(negedge clk);
      n++;
    end
    check_eq("R11 request held one period", int'(n >= 8 * MAIN_GAP), 1);
    check_eq("R11 request released", sys_rst_req, 0);
  endtask

  task automatic t_freeze();
    bus_write(8'hF5, 8'h44);
    vdet_lo = 1'b1;
    repeat (6) @(negedge clk);
    check_eq("R6 freeze request", freeze_req, 1);
    check_eq("R6 reset suppressed", sys_rst_req, 0);
    vdet_lo = 1'b0;
    repeat (6) @(negedge clk);
    check_eq("R6 freeze clears", freeze_req, 0);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    bus_write(8'hF5, 8'h84);
    vdet_lo = 1'b1;
    vdet_hi = 1'b1;
    repeat (6) @(negedge clk);
    check_eq("R7 no reset when off", sys_rst_req, 0);
    check_eq("R7 no freeze when off", freeze_req, 0);
    bus_read(8'hF5, d);
    check_eq("R7 flags read zero", d, 8'h84);
    bus_write(8'hF5, 8'h04);
    repeat (3) @(negedge clk);
    bus_read(8'hF5, d);
    check_eq("R7 flags back when on", d, 8'h34);
    check_eq("R7 reset back when on", sys_rst_req, 1);
    vdet_lo = 1'b0;
    vdet_hi = 1'b0;
    repeat (200) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_boundary();
    t_sources();
    t_flags();
    t_reset_req();
    t_freeze();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule